// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a serial slave for a two-wire bus with one clock line and one data line. It lets a bus master write and read a small file of 8-bit registers, addressed by a 7-bit index. Both bus lines are brought into the system clock domain and sampled there. The data line is only ever pulled low, through an enable output that drives an open-drain pad. The block detects start and stop conditions and compares the incoming 7-bit device address with its own. It acknowledges every byte it accepts. For a read, it shifts out register contents after a repeated start.

One control bit, bit 0 of register 3, selects between single-byte transfers and bursts that advance the register index. Registers 1 and 2 hold a fixed identity. A write to register 0 puts every register back to its default. The lowest bit of the device address comes from a strap input, which is captured once when reset is released.

Top module: `twowire_regslave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. After a stop the slave is idle and does not pull the data line.
- R2: The device address is 0111010 when `addr_sel` is low on the first clock after reset release, and 0111011 when it is high. Later changes of `addr_sel` have no effect until the next reset.
- R3: The first byte after a start is the 7-bit device address, MSB first, followed by a direction bit (0 write, 1 read). On a match the slave pulls the data line low during the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R4: A write transfer is the address byte with direction 0, then an index byte whose bit 7 is ignored, then data. Every accepted byte is acknowledged, and the data lands in the indexed register.
- R5: With bit 0 of register 3 at 0, one write transfer stores only its first data byte. Every later byte in that transfer is not acknowledged and is not stored.
- R6: With bit 0 of register 3 at 1, consecutive data bytes of one write transfer go to increasing register indices, and each of them is acknowledged.
- R7: A read is the address with direction 0, the index byte, a repeated start, and the address with direction 1. The slave returns register data MSB first. A master NACK followed by a stop ends the read.
- R8: While the master acknowledges read bytes, the next byte comes from the next higher index when bit 0 of register 3 is 1, and from the same index again when it is 0.
- R9: Register 1 reads 0x88 and register 2 reads 0x05. Register 0 and any index at or above NUM_REGS read 0x00. Writes to these indices are acknowledged but change no stored value.
- R10: A write to register 0 returns every register, including register 3, to its default of 0x00. A burst that is under way then falls under the single-byte rule.
- R11: A stop or start that arrives in the middle of a byte abandons the transfer: the partial byte is not stored. After a start, a new address byte is expected.
- R12: The data-line pull-down enable changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| addr_sel | input | 1 | Strap that picks the device address LSB, captured after reset |
| sda_pull_low | output | 1 | When 1, the pad pulls the data line low |

## Verification
Two functions can act on the same system clock edge: the soft reset caused by a write to register 0, and the index advance of a burst write. Both are triggered by the same accepted byte. The bench provokes this by setting the burst bit and then bursting two bytes that start at index 0. It judges the result at the pins. The second byte must be refused, because the reset cleared the burst bit. A value written beforehand to another register must read back as zero, and the identity register must still read 0x88.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_IDX,
    ST_WR,
    ST_RD,
    ST_HOLD
  } twr_state_e;

  // upper six bits of the device address; LSB comes from the strap
  localparam logic [5:0] DEV_ADDR_HI = 6'b011101;

  localparam int IDX_SOFTRST = 0;
  localparam int IDX_ID_A    = 1;
  localparam int IDX_ID_B    = 2;
  localparam int IDX_CTRL    = 3;

  localparam logic [7:0] ID_A_VAL = 8'h88;
  localparam logic [7:0] ID_B_VAL = 8'h05;
  localparam logic [7:0] REG_DEFAULT = 8'h00;

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/twr_cond.sv
module twr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise = scl_s & ~scl_q;
    scl_fall = ~scl_s & scl_q;
    start_c  = scl_s & scl_q & sda_q & ~sda_s;
    stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/twr_regfile.sv
module twr_regfile
  import twr_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int AW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic          cont
);

  localparam int IW = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][7:0] rval;
  logic soft_rst;

  assign soft_rst = we && (waddr == AW'(IDX_SOFTRST));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_SOFTRST) begin : g_zero
      assign rval[i] = 8'h00;
    end else if (i == IDX_ID_A) begin : g_ida
      assign rval[i] = ID_A_VAL;
    end else if (i == IDX_ID_B) begin : g_idb
      assign rval[i] = ID_B_VAL;
    end else begin : g_rw
      logic [7:0] q, d;
      logic       en;
      always_comb begin
        en = soft_rst || (we && (waddr == AW'(i)));
        d  = soft_rst ? REG_DEFAULT : wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= REG_DEFAULT;
        else if (en) q <= d;
      end
      assign rval[i] = q;
    end
  end

  always_comb begin
    if (int'(raddr) < NUM_REGS) rdata = rval[raddr[IW-1:0]];
    else                        rdata = 8'h00;
  end

  assign cont = rval[IDX_CTRL][0];

endmodule

// File: rtl/twr_proto.sv
module twr_proto
  import twr_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic          sda_s,
  input  logic          strap,
  input  logic          cont,
  input  logic [7:0]    rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] ptr,
  output twr_state_e    st,
  output logic          sda_oe
);

  twr_state_e   st_n;
  logic [3:0]   cnt, cnt_n;
  logic         ackph, ack_n;
  logic [7:0]   sh, sh_n;
  logic [7:0]   rsh, rsh_n;
  logic [AW-1:0] ptr_n;
  logic         wrote, wrote_n;
  logic         oe_n;
  logic         dev_hit, accept_wr;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    ack_n   = ackph;
    sh_n    = sh;
    rsh_n   = rsh;
    ptr_n   = ptr;
    wrote_n = wrote;
    oe_n    = sda_oe;
    we      = 1'b0;
    dev_hit   = (sh[7:1] == {DEV_ADDR_HI, strap});
    accept_wr = cont || !wrote;

    if (stop_c) begin
      st_n = ST_IDLE; oe_n = 1'b0; ack_n = 1'b0; cnt_n = '0;
    end else if (start_c) begin
      st_n = ST_DEV;  oe_n = 1'b0; ack_n = 1'b0; cnt_n = '0;
    end else begin
      case (st)
        ST_DEV, ST_IDX, ST_WR: begin
          if (scl_rise) begin
            if (!ackph && cnt != 4'd8) begin
              sh_n  = {sh[6:0], sda_s};
              cnt_n = cnt + 4'd1;
            end
          end else if (scl_fall) begin
            if (ackph) begin
              ack_n = 1'b0;
              oe_n  = 1'b0;
            end else if (cnt == 4'd8) begin
              cnt_n = '0;
              if (st == ST_DEV) begin
                if (dev_hit) begin
                  ack_n = 1'b1;
                  oe_n  = 1'b1;
                  st_n  = sh[0] ? ST_RD : ST_IDX;
                end else begin
                  st_n = ST_IDLE;
                end
              end else if (st == ST_IDX) begin
                ack_n   = 1'b1;
                oe_n    = 1'b1;
                ptr_n   = sh[AW-1:0];
                wrote_n = 1'b0;
                st_n    = ST_WR;
              end else begin
                if (accept_wr) begin
                  ack_n   = 1'b1;
                  oe_n    = 1'b1;
                  we      = 1'b1;
                  wrote_n = 1'b1;
                  if (cont) ptr_n = ptr + AW'(1);
                end else begin
                  st_n = ST_HOLD;
                end
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            if (!ackph) begin
              cnt_n = cnt + 4'd1;
            end else if (sda_s) begin
              st_n  = ST_HOLD;
              ack_n = 1'b0;
              oe_n  = 1'b0;
            end
          end else if (scl_fall) begin
            if (ackph) begin
              ack_n = 1'b0;
              cnt_n = '0;
              oe_n  = ~rdata[7];
              rsh_n = {rdata[6:0], 1'b0};
            end else if (cnt == 4'd8) begin
              ack_n = 1'b1;
              oe_n  = 1'b0;
              if (cont) ptr_n = ptr + AW'(1);
            end else if (cnt != 4'd0) begin
              oe_n  = ~rsh[7];
              rsh_n = {rsh[6:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ackph  <= 1'b0;
      sh     <= '0;
      rsh    <= '0;
      ptr    <= '0;
      wrote  <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      ackph  <= ack_n;
      sh     <= sh_n;
      rsh    <= rsh_n;
      ptr    <= ptr_n;
      wrote  <= wrote_n;
      sda_oe <= oe_n;
    end
  end

  assign waddr = ptr;
  assign wdata = sh;

endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave
  import twr_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic addr_sel,
  output logic sda_pull_low
);

  localparam int AW = 7;

  logic [1:0] rst_pipe;
  logic       rst_ns;
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic       strap_q, strap_done;
  logic       we, cont;
  logic [AW-1:0] waddr, ptr;
  logic [7:0] wdata, rdata;
  twr_state_e st;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  // strap captured once on the first clock after release
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      strap_q    <= 1'b0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= addr_sel;
      strap_done <= 1'b1;
    end
  end

  twr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_ns),
    .d    ({scl_in, sda_in}),
    .q    (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  twr_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_ns),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  twr_proto #(.AW(AW)) u_proto (
    .clk     (clk),
    .rst_n   (rst_ns),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c),
    .sda_s   (sda_s),
    .strap   (strap_q),
    .cont    (cont),
    .rdata   (rdata),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .ptr     (ptr),
    .st      (st),
    .sda_oe  (sda_pull_low)
  );

  twr_regfile #(.NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
    .clk  (clk),
    .rst_n(rst_ns),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(ptr),
    .rdata(rdata),
    .cont (cont)
  );

endmodule

// File: rtl/twr_chk.sv
module twr_chk
  import twr_pkg::*;
(
  input logic       clk,
  input logic       rst_ns,
  input logic       scl_s,
  input logic       start_c,
  input logic       stop_c,
  input twr_state_e st,
  input logic [6:0] ptr,
  input logic       cont,
  input logic       sda_pull_low,
  input logic       strap_q,
  input logic       strap_done
);

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(sda_pull_low) |-> !$past(scl_s));

  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    stop_c |=> (st == ST_IDLE));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (st == ST_IDLE) |-> !sda_pull_low);

  p_start_addr_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (start_c && !stop_c) |=> (st == ST_DEV));

  p_single_ptr_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (st == ST_WR && !cont) |=> $stable(ptr));

  p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    strap_done |=> $stable(strap_q));

endmodule

bind twowire_regslave twr_chk u_chk (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .scl_s       (scl_s),
  .start_c     (start_c),
  .stop_c      (stop_c),
  .st          (st),
  .ptr         (ptr),
  .cont        (cont),
  .sda_pull_low(sda_pull_low),
  .strap_q     (strap_q),
  .strap_done  (strap_done)
);

// File: tb/sim_twowire_regslave.sv
module sim_twowire_regslave;

  localparam int Q  = 8;
  localparam int WD = 150000;
  localparam logic [6:0] ADDR_LO = 7'h3A;
  localparam logic [6:0] ADDR_HI = 7'h3B;

  // {write index byte, read index, data, expected read}
  localparam logic [31:0] VEC [8] = '{
    32'h0404A5A5, 32'h0F0F3C3C, 32'h01010088, 32'h0202FF05,
    32'h14147700, 32'h86065A5A, 32'h0808C3C3, 32'h00001200
  };

  logic clk = 1'b0;
  logic rst_n, m_scl, m_sda, addr_sel;
  logic sda_bus, sda_pull_low;
  logic [6:0] dev;
  logic [7:0] rbuf [4];
  logic [7:0] wbuf [4];
  int checks = 0, errors = 0, oe_viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull_low;

  twowire_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .addr_sel(addr_sel), .sda_pull_low(sda_pull_low)
  );

  // R12: pull-down must not move while the clock line is high
  always @(negedge clk) begin
    if (rst_n === 1'b1 && m_scl === 1'b1 && sda_pull_low !== prev_oe) oe_viol++;
    prev_oe = sda_pull_low;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit strap);
    rst_n = 1'b0; addr_sel = strap; m_scl = 1'b1; m_sda = 1'b1;
    wq(4);
    rst_n = 1'b1;
    wq(8);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic put_bit(bit b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2);
    ack = (sda_bus == 1'b0);
    wq(Q/2); m_scl = 1'b0; wq(Q);
  endtask

  task automatic get_byte(bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2);
      b[i] = sda_bus;
      wq(Q/2); m_scl = 1'b0; wq(Q);
    end
    put_bit(!give_ack);
  endtask

  task automatic write_tx(logic [7:0] idx, int n, logic [3:0] exp_ack, string tag);
    bit a;
    bus_start();
    send_byte({dev, 1'b0}, a); chk("R3 address ack on write", a, 1);
    send_byte(idx, a);         chk("R4 index ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk($sformatf("%s byte %0d", tag, i), a, exp_ack[i]);
    end
    bus_stop();
  endtask

  task automatic read_tx(logic [7:0] idx, int n);
    bit a;
    bus_start();
    send_byte({dev, 1'b0}, a); chk("R7 address ack before index", a, 1);
    send_byte(idx, a);         chk("R7 index ack on read", a, 1);
    bus_start();
    send_byte({dev, 1'b1}, a); chk("R7 address ack after repeated start", a, 1);
    for (int i = 0; i < n; i++) get_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  initial begin : wd
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit a;
    dev = ADDR_LO;
    do_reset(1'b0);
    chk("R12 no pull after reset", sda_pull_low, 0);

    // vector table: R4 store, R9 fixed and absent registers, R10 reset write
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][15:8];
      write_tx(VEC[v][31:24], 1, 4'b0001, "R4 data ack");
      read_tx(VEC[v][23:16], 1);
      chk($sformatf("R4 R9 vector %0d readback", v), rbuf[0], VEC[v][7:0]);
    end
    read_tx(8'h04, 1);
    chk("R10 register 4 cleared by write to 0", rbuf[0], 8'h00);

    // R3 mismatch, then R1 idle after stop
    bus_start();
    send_byte({ADDR_HI, 1'b0}, a); chk("R3 mismatch not acked", a, 0);
    send_byte(8'h05, a);           chk("R3 bytes after mismatch ignored", a, 0);
    bus_stop();
    chk("R1 no pull after stop", sda_pull_low, 0);

    // R5 single byte per write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_tx(8'h04, 2, 4'b0001, "R5 second byte refused");
    read_tx(8'h04, 1); chk("R5 first byte stored", rbuf[0], 8'h11);
    read_tx(8'h05, 1); chk("R5 extra byte not stored", rbuf[0], 8'h00);

    // R6 burst write, R8 burst read
    wbuf[0] = 8'h01; write_tx(8'h03, 1, 4'b0001, "R6 control write");
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    write_tx(8'h08, 3, 4'b0111, "R6 burst ack");
    read_tx(8'h08, 3);
    chk("R7 first read byte", rbuf[0], 8'hA1);
    chk("R8 burst read second", rbuf[1], 8'hA2);
    chk("R8 burst read third", rbuf[2], 8'hA3);

    // R8 repeat same register when burst off
    wbuf[0] = 8'h00; write_tx(8'h03, 1, 4'b0001, "R6 control clear");
    read_tx(8'h08, 2);
    chk("R8 repeat first", rbuf[0], 8'hA1);
    chk("R8 repeat second", rbuf[1], 8'hA1);

    // R11 stop in mid byte
    wbuf[0] = 8'h5E; write_tx(8'h09, 1, 4'b0001, "R11 setup");
    bus_start();
    send_byte({dev, 1'b0}, a); send_byte(8'h09, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    read_tx(8'h09, 1); chk("R11 partial byte after stop not stored", rbuf[0], 8'h5E);

    // R11 start in mid byte
    bus_start();
    send_byte({dev, 1'b0}, a); send_byte(8'h09, a);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_start();
    send_byte({dev, 1'b0}, a); chk("R11 address accepted after mid-byte start", a, 1);
    send_byte(8'h0A, a); send_byte(8'h6B, a);
    bus_stop();
    read_tx(8'h09, 1); chk("R11 register 9 kept", rbuf[0], 8'h5E);
    read_tx(8'h0A, 1); chk("R11 fresh transfer stored", rbuf[0], 8'h6B);

    // R10 soft reset and burst advance on the same byte
    wbuf[0] = 8'h01; write_tx(8'h03, 1, 4'b0001, "R10 burst on");
    wbuf[0] = 8'h44; write_tx(8'h0C, 1, 4'b0001, "R10 setup");
    wbuf[0] = 8'h00; wbuf[1] = 8'h99;
    write_tx(8'h00, 2, 4'b0001, "R10 byte after reset refused");
    read_tx(8'h0C, 1); chk("R10 register 12 cleared", rbuf[0], 8'h00);
    read_tx(8'h03, 1); chk("R10 control cleared", rbuf[0], 8'h00);
    read_tx(8'h01, 1); chk("R9 identity intact", rbuf[0], 8'h88);

    // R2 strap change ignored after capture
    addr_sel = 1'b1;
    read_tx(8'h01, 1); chk("R2 strap change ignored", rbuf[0], 8'h88);

    // R2 strap high at reset
    do_reset(1'b1);
    dev = ADDR_HI;
    read_tx(8'h02, 1); chk("R2 high address reads identity", rbuf[0], 8'h05);
    bus_start();
    send_byte({ADDR_LO, 1'b0}, a); chk("R2 low address refused", a, 0);
    bus_stop();

    chk("R12 pull changed while clock high", oe_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule